// File: doc/BRIEF.md
# CRC-32C Accumulator

This block folds one chunk of data per clock into a running 32-bit checksum built on the Castagnoli generator polynomial. Each operation brings in three things: a 64-bit destination value whose low 32 bits hold the checksum so far, a data word of up to 64 bits, and a two-bit code that picks how many of the data bits take part. The updated checksum comes back in the low half of a 64-bit result, one cycle after the strobe.

A caller walks a message by feeding each result back as the next destination value, so the checksum builds up across the loop. The chunk width may change from one operation to the next, so a message can be covered with wide chunks and finished with narrow ones. The block applies no seed and no final inversion of its own. To get the standard check value, the caller seeds with all ones and inverts the final result.

Top module: `crc32c_accum`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `out_valid` is 0 and `out_crc` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_crc` holds its value and `out_valid` goes to 0 one cycle later.
- R3: Width code 2'b00 folds `in_data[7:0]`, least significant bit first, and ignores `in_data[63:8]`.
- R4: Width code 2'b01 folds `in_data[15:0]`, least significant bit first.
- R5: Width code 2'b10 folds `in_data[31:0]`, least significant bit first.
- R6: Width code 2'b11 folds all 64 bits of `in_data`, least significant bit first.
- R7: Only `in_crc[31:0]` feeds the update and `in_crc[63:32]` is ignored. `out_crc[63:32]` is always zero.
- R8: The block applies no seed XOR and no final XOR. A zero checksum folded with all-zero data gives zero.
- R9: Seeding with 0xFFFFFFFF, folding the ASCII bytes "123456789" (first byte in bits 7:0) and inverting the result gives 0xE3069283.
- R10: Results do not depend on how the data is split into chunks. Folding one 64-bit chunk equals folding its eight bytes in order. 32 zero bytes give 0x8A9136AA, and 32 bytes of 0xFF give 0x62A8AB43 (both seeded with all ones and inverted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: fold this chunk |
| in_width | input | 2 | Chunk width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_crc | input | 64 | Previous destination value; only bits 31:0 are used |
| in_data | input | 64 | Data word, low-order bits used first |
| out_valid | output | 1 | Result registered from the previous cycle's strobe |
| out_crc | output | 64 | Updated checksum in bits 31:0, bits 63:32 zero |

## Verification
The bench targets the following corner cases:
- Bit order and polynomial reflection. A design that shifts the wrong way or uses the unreflected polynomial misses the "123456789" check value and the 32-byte vectors.
- Chunk width selection. Junk is placed in the upper data bits for each width code. A wrong lane decode or a missing mask changes the 8-bit result and breaks the equivalence between one 64-bit chunk and eight byte chunks.
- Upper half of the destination operand. Nonzero bits are supplied there. A design that leaked them in, or failed to clear them on output, would show nonzero high bits.
- Behaviour with the strobe low. Idle cycles are checked for a held result, so a register loading on every clock would be caught.

// File: rtl/crc32c_pkg.sv
`timescale 1ns/1ps
package crc32c_pkg;
   // Reflected Castagnoli generator (x^32 term dropped, bit order reversed)
   localparam int          CRC_BITS   = 32;
   localparam logic [31:0] POLY_REFL  = 32'h82F63B78;

   typedef enum logic [1:0] {
      CHUNK_8  = 2'b00,
      CHUNK_16 = 2'b01,
      CHUNK_32 = 2'b10,
      CHUNK_64 = 2'b11
   } chunk_code_e;
endpackage

// File: rtl/crc32c_fold.sv
`timescale 1ns/1ps
// Combinational fold of CHUNK_BITS data bits into a reflected CRC, LSB first.
module crc32c_fold #(
   parameter int                CRC_W      = 32,
   parameter int                CHUNK_BITS = 8,
   parameter logic [CRC_W-1:0]  POLY       = crc32c_pkg::POLY_REFL
) (
   input  logic [CRC_W-1:0]      crc_i,
   input  logic [CHUNK_BITS-1:0] data_i,
   output logic [CRC_W-1:0]      crc_o
);
   generate
      if (CHUNK_BITS < 1 || CHUNK_BITS > 64) begin : g_bad_chunk
         $error("crc32c_fold: CHUNK_BITS out of range");
      end
      if (CRC_W < 2) begin : g_bad_crc
         $error("crc32c_fold: CRC_W too small");
      end
   endgenerate

   logic [CRC_W-1:0] acc;

   always_comb begin
      acc = crc_i;
      for (int i = 0; i < CHUNK_BITS; i++) begin
         acc = acc ^ {{(CRC_W-1){1'b0}}, data_i[i]};
         acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
      end
      crc_o = acc;
   end
endmodule

// File: rtl/crc32c_lane_sel.sv
`timescale 1ns/1ps
// Picks one lane result by width code.
module crc32c_lane_sel #(
   parameter int CRC_W     = 32,
   parameter int NUM_LANES = 4,
   localparam int SEL_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic [NUM_LANES-1:0][CRC_W-1:0] lanes_i,
   input  logic [SEL_W-1:0]                sel_i,
   output logic [CRC_W-1:0]                crc_o
);
   always_comb begin
      crc_o = lanes_i[0];
      for (int k = 0; k < NUM_LANES; k++) begin
         if (sel_i == SEL_W'(k)) crc_o = lanes_i[k];
      end
   end
endmodule

// File: rtl/crc32c_accum.sv
`timescale 1ns/1ps
module crc32c_accum #(
   parameter int                CRC_W     = crc32c_pkg::CRC_BITS,
   parameter int                DATA_W    = 64,
   parameter int                DEST_W    = 64,
   parameter logic [CRC_W-1:0]  POLY      = crc32c_pkg::POLY_REFL,
   localparam int               NUM_LANES = $clog2(DATA_W / 8) + 1,
   localparam int               SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SEL_W-1:0]  in_width,
   input  logic [DEST_W-1:0] in_crc,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DEST_W-1:0] out_crc
);
   generate
      if (DATA_W != (8 << (NUM_LANES - 1))) begin : g_bad_data
         $error("crc32c_accum: DATA_W must be 8 times a power of two");
      end
      if (DEST_W < CRC_W) begin : g_bad_dest
         $error("crc32c_accum: DEST_W narrower than CRC_W");
      end
   endgenerate

   logic [NUM_LANES-1:0][CRC_W-1:0] lane_crc;
   logic [CRC_W-1:0]                next_crc;
   logic [CRC_W-1:0]                crc_q;
   logic                            vld_q;
   logic                            unused_hi;

   assign unused_hi = ^in_crc[DEST_W-1:CRC_W];

   // One fold lane per legal chunk width: 8, 16, 32, ... DATA_W bits
   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      localparam int LW = 8 << k;
      crc32c_fold #(
         .CRC_W      (CRC_W),
         .CHUNK_BITS (LW),
         .POLY       (POLY)
      ) u_fold (
         .crc_i  (in_crc[CRC_W-1:0]),
         .data_i (in_data[LW-1:0]),
         .crc_o  (lane_crc[k])
      );
   end

   crc32c_lane_sel #(
      .CRC_W     (CRC_W),
      .NUM_LANES (NUM_LANES)
   ) u_sel (
      .lanes_i (lane_crc),
      .sel_i   (in_width),
      .crc_o   (next_crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) crc_q <= next_crc;
      end
   end

   assign out_valid = vld_q;
   assign out_crc   = {{(DEST_W-CRC_W){1'b0}}, crc_q};

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                          // R2
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                        // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_crc));                                  // R2
   AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      out_crc[DEST_W-1:CRC_W] == '0);                                   // R7
   AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_crc[CRC_W-1:0] == '0 && in_data == '0)
      |=> out_crc == '0);                                               // R8
endmodule

// File: tb/sim_crc32c_accum.sv
`timescale 1ns/1ps
module sim_crc32c_accum;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_width = 2'b00;
   logic [63:0] in_crc = '0;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic [63:0] out_crc;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   crc32c_accum u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_width(in_width),
      .in_crc(in_crc), .in_data(in_data), .out_valid(out_valid), .out_crc(out_crc)
   );

   // Reference from the requirement text: reflected, LSB first, polynomial 0x82F63B78
   function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [63:0] d,
                                            input int nbits);
      logic [31:0] r = c;
      for (int i = 0; i < nbits; i++) begin
         r[0] = r[0] ^ d[i];
         if (r[0]) r = (r >> 1) ^ 32'h82F63B78;
         else      r = r >> 1;
      end
      return r;
   endfunction

   function automatic string width_tag(input logic [1:0] w);
      case (w)
         2'b00:   return "R3";
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive at the falling edge, sample 1 ns after the rising edge that registers it
   task automatic op(input logic [63:0] c, input logic [63:0] d, input logic [1:0] w,
                     output logic [63:0] r);
      @(negedge clk);
      in_valid = 1'b1; in_crc = c; in_data = d; in_width = w;
      @(posedge clk); #1;
      chk("R2 valid", {63'b0, out_valid}, 64'd1);
      r = out_crc;
      in_valid = 1'b0;
   endtask

   localparam int NT = 6;
   localparam logic [63:0] T_CRC [NT] = '{
      64'h0000_0000_FFFF_FFFF, 64'h0000_0000_1234_5678, 64'h0000_0000_0BAD_F00D,
      64'h0000_0000_8000_0000, 64'hA5A5_A5A5_1234_5678, 64'hFFFF_FFFF_0000_0001 };
   localparam logic [63:0] T_DATA [NT] = '{
      64'hDEAD_BEEF_CAFE_F00D, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_8000_0001,
      64'h8000_0000_0000_0001, 64'h5555_AAAA_3C3C_C3C3, 64'h0000_0000_0000_00FF };
   localparam logic [1:0] T_W [NT] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b00};

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] r, r2, held;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 valid in reset", {63'b0, out_valid}, 64'd0);
      chk("R1 crc in reset", out_crc, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 valid after reset", {63'b0, out_valid}, 64'd0);
      chk("R1 crc after reset", out_crc, 64'd0);

      // Table walk: widths R3..R6, upper destination bits R7
      for (int i = 0; i < NT; i++) begin
         op(T_CRC[i], T_DATA[i], T_W[i], r);
         chk(width_tag(T_W[i]), r,
             {32'h0, ref_fold(T_CRC[i][31:0], T_DATA[i], 8 << T_W[i])});
         chk("R7 upper zero", {32'h0, r[63:32]}, 64'd0);
      end

      // R3: upper data bits ignored at 8-bit width
      op(64'h0000_0000_5A5A_1234, 64'hFFFF_FFFF_FFFF_FF42, 2'b00, r);
      op(64'h0000_0000_5A5A_1234, 64'h0000_0000_0000_0042, 2'b00, r2);
      chk("R3 upper data ignored", r, r2);

      // R2: idle cycles hold the result and drop valid
      held = r2;
      @(negedge clk); in_data = 64'h1111_2222_3333_4444; in_crc = 64'hFFFF;
      @(posedge clk); #1;
      chk("R2 valid drops", {63'b0, out_valid}, 64'd0);
      @(posedge clk); #1;
      chk("R2 crc held", out_crc, held);

      // R8: no internal inversion
      op(64'h0, 64'h0, 2'b11, r);
      chk("R8 zero in zero out", r, 64'h0);
      op(64'hFFFF_FFFF_0000_0000, 64'h0, 2'b00, r);
      chk("R8 R7 zero with high junk", r, 64'h0);

      // R9: check value for "123456789"
      op(64'hFFFF_FFFF, 64'h3837_3635_3433_3231, 2'b11, r);
      op(r, 64'h39, 2'b00, r2);
      chk("R9 check value", {32'h0, r2[31:0] ^ 32'hFFFF_FFFF}, 64'h0000_0000_E306_9283);

      // R10: chunking independence and known 32-byte vectors
      r = 64'hFFFF_FFFF;
      for (int k = 0; k < 4; k++) op(r, 64'h0, 2'b11, r);
      chk("R10 32 zero bytes", {32'h0, r[31:0] ^ 32'hFFFF_FFFF}, 64'h0000_0000_8A91_36AA);
      r = 64'hFFFF_FFFF;
      for (int k = 0; k < 8; k++) op(r, 64'hFFFF_FFFF, 2'b10, r);
      chk("R10 32 ones bytes", {32'h0, r[31:0] ^ 32'hFFFF_FFFF}, 64'h0000_0000_62A8_AB43);
      op(64'h89AB_CDEF, 64'h0F1E_2D3C_4B5A_6978, 2'b11, r);
      r2 = 64'h89AB_CDEF;
      for (int k = 0; k < 8; k++)
         op(r2, {56'hFFFF_FFFF_FFFF_FF, 8'(64'h0F1E_2D3C_4B5A_6978 >> (8 * k))}, 2'b00, r2);
      chk("R10 one wide chunk equals eight bytes", r, r2);
      op(64'h89AB_CDEF, 64'h0F1E_2D3C_4B5A_6978, 2'b10, r);
      op(r, 64'h0F1E_2D3C, 2'b01, r);
      op(r, 64'h0F1E, 2'b00, r);
      op(r, 64'h0F, 2'b00, r);
      chk("R10 mixed widths", r, r2);

      // R1: reset in the middle of operation clears state
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R1 crc cleared by reset", out_crc, 64'h0);
      chk("R1 valid cleared by reset", {63'b0, out_valid}, 64'd0);
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule